// File: doc/BRIEF.md
# Codec Serial Clock and Frame-Sync Generator

This block makes the serial timing for an audio converter port that drives its own clocks. It runs from a single master clock. It produces four outputs:

- a shift clock at one quarter of the master clock rate;
- a filter clock whose period is set by a programmable divisor A;
- an active-low frame-sync that opens a 16-bit transfer window once per sample period;
- a one-cycle strobe that marks the first master clock of each sample period.

The filter clock is counted by a second programmable divisor B. One sample period therefore lasts 2·A·B master clocks. After reset the block stays silent for a fixed startup delay before it opens the first frame.

All outputs are produced in the master clock domain, as levels taken from registers. The divisors come from a register interface outside this block. They are taken only at the start of a sample period, so a new setting never produces a shortened period. The state machine has three states:

- `ST_HOLD`: startup wait.
- `ST_FRAME`: frame-sync is active.
- `ST_GAP`: rest of the sample period.

Its transitions are:

- HOLD→FRAME when the startup count is done.
- FRAME→GAP when 64 master clocks of the frame have passed.
- FRAME→FRAME when a period ends during the frame.
- GAP→FRAME when the period ends.

Top module: `codec_timing_gen`

## Requirements
- R1: After reset is released, `fs_n` stays high and `sclk`, `fclk` and `frame_start` stay low until the STARTUP_CYC-th (default 648) rising clock edge. The first sample period begins on that edge.
- R2: Within a sample period, `sclk` has a period of 4 master clocks. It is high for the first 2 and low for the next 2, and its phase restarts high on the first cycle of every sample period.
- R3: `fclk` has a period of 2·A master clocks. It is high for the first A cycles of each of its periods, and the first of these periods starts with the sample period.
- R4: Successive sample periods start exactly 2·A·B master clocks apart.
- R5: `fs_n` is low for the first 64 master clocks (16 shift clocks) of each sample period, then high. If the period is shorter than 64 clocks, `fs_n` stays low.
- R6: `fs_n` falls only in a cycle in which `sclk` is high, that is, with a rising shift-clock edge.
- R7: A change on `div_a` or `div_b` takes effect only from the next sample-period start. The period already running keeps the values it was started with.
- R8: A divisor input of 0 behaves as the value 1.
- R9: `frame_start` is high for exactly the first master clock of each sample period, and only while `fs_n` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| mclk | input | 1 | Master clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| div_a | input | DIV_W | Filter-clock divisor A |
| div_b | input | DIV_W | Sample-period divisor B, counted in filter-clock periods |
| sclk | output | 1 | Shift clock, master clock / 4 |
| fclk | output | 1 | Filter clock, master clock / (2·A) |
| fs_n | output | 1 | Active-low frame-sync, 64 master clocks long |
| frame_start | output | 1 | Pulse on the first master clock of each sample period |

## Verification
The assertions take for granted that the divisor inputs are constant or change only between master-clock edges. They do not assume that the inputs stay stable across a period, because the latching is what shields the counters. The bench drives the divisors on the falling clock edge, right after a period start has been seen. Each change therefore lands inside a running period, which must ignore it. The bench sweeps every A and B from 0 to 15, so it covers both the zero-as-one rule and periods shorter than one frame.

// File: rtl/codec_tg_pkg.sv
package codec_tg_pkg;

    typedef enum logic [1:0] {
        ST_HOLD  = 2'd0,
        ST_FRAME = 2'd1,
        ST_GAP   = 2'd2
    } tg_state_e;

    localparam int SCLK_RATIO = 4;

endpackage

// File: rtl/tg_startup.sv
module tg_startup #(
    parameter int CYC = 648
) (
    input  logic clk,
    input  logic rst_n,
    output logic go
);
    localparam int W = $clog2(CYC + 1);
    localparam logic [W-1:0] LAST = W'(CYC - 1);

    logic [W-1:0] cnt_q;
    logic         done_q;

    assign go = !done_q && (cnt_q == LAST);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            done_q <= 1'b0;
        end else if (go) begin
            done_q <= 1'b1;
        end else if (!done_q) begin
            cnt_q <= cnt_q + W'(1);
        end
    end

    // R1: the startup release happens once and stays
    a_r1_done_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        done_q |=> done_q);
    a_r1_go_once: assert property (@(posedge clk) disable iff (!rst_n)
        go |=> !go);

endmodule

// File: rtl/tg_divchain.sv
module tg_divchain #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             restart,
    input  logic             run,
    input  logic [DIV_W-1:0] div_a,
    input  logic [DIV_W-1:0] div_b,
    output logic             fclk,
    output logic             period_end
);
    localparam logic [DIV_W-1:0] ONE = DIV_W'(1);

    function automatic logic [DIV_W-1:0] clamp_div(input logic [DIV_W-1:0] v);
        return (v == '0) ? ONE : v;
    endfunction

    logic [DIV_W-1:0] a_lat, b_lat, a_cnt, b_cnt;
    logic             half_q;
    logic             a_wrap, b_wrap;

    assign a_wrap     = (a_cnt == a_lat - ONE);
    assign b_wrap     = (b_cnt == b_lat - ONE);
    assign period_end = run && half_q && a_wrap && b_wrap;
    assign fclk       = run && !half_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            a_lat  <= ONE;
            b_lat  <= ONE;
            a_cnt  <= '0;
            b_cnt  <= '0;
            half_q <= 1'b0;
        end else if (restart) begin
            a_lat  <= clamp_div(div_a);
            b_lat  <= clamp_div(div_b);
            a_cnt  <= '0;
            b_cnt  <= '0;
            half_q <= 1'b0;
        end else if (run) begin
            if (a_wrap) begin
                a_cnt  <= '0;
                half_q <= !half_q;
                if (half_q) begin
                    b_cnt <= b_wrap ? '0 : b_cnt + ONE;
                end
            end else begin
                a_cnt <= a_cnt + ONE;
            end
        end
    end

    // R7: divisors only move at a period start
    a_r7_latch_stable: assert property (@(posedge clk) disable iff (!rst_n)
        !restart |=> ($stable(a_lat) && $stable(b_lat)));
    // R8: effective divisors are never zero
    a_r8_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
        (a_lat != '0) && (b_lat != '0));
    // R3: the A counter stays inside its range
    a_r3_a_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        (a_cnt < a_lat) && (b_cnt < b_lat));

endmodule

// File: rtl/tg_frame_fsm.sv
module tg_frame_fsm
    import codec_tg_pkg::*;
#(
    parameter int FRAME_CYC = 64
) (
    input  logic clk,
    input  logic rst_n,
    input  logic go,
    input  logic period_end,
    output logic restart,
    output logic run,
    output logic sclk,
    output logic fs_n,
    output logic frame_start
);
    localparam int FW = $clog2(FRAME_CYC);
    localparam logic [FW-1:0] F_LAST = FW'(FRAME_CYC - 1);

    tg_state_e      state_q, state_d;
    logic [1:0]     sph_q;
    logic [FW-1:0]  fcnt_q;

    assign restart = go || period_end;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_HOLD:  if (go) state_d = ST_FRAME;
            ST_FRAME: begin
                if (period_end)           state_d = ST_FRAME;
                else if (fcnt_q == F_LAST) state_d = ST_GAP;
            end
            ST_GAP:   if (period_end) state_d = ST_FRAME;
            default:  state_d = ST_HOLD;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_HOLD;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sph_q  <= '0;
            fcnt_q <= '0;
        end else if (restart) begin
            sph_q  <= '0;
            fcnt_q <= '0;
        end else if (state_q != ST_HOLD) begin
            sph_q <= sph_q + 2'd1;
            if (state_q == ST_FRAME && fcnt_q != F_LAST) fcnt_q <= fcnt_q + FW'(1);
        end
    end

    always_comb begin
        run         = (state_q != ST_HOLD);
        sclk        = run && !sph_q[1];
        fs_n        = (state_q != ST_FRAME);
        frame_start = (state_q == ST_FRAME) && (fcnt_q == '0);
    end

    // R6: frame opens together with a rising shift-clock edge
    a_r6_fs_on_sclk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(fs_n) |-> sclk);
    // R9: the strobe only appears inside the frame window
    a_r9_start_in_frame: assert property (@(posedge clk) disable iff (!rst_n)
        frame_start |-> !fs_n);
    // R5: a full frame closes at the end of a shift-clock period
    a_r5_frame_close: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(fs_n) |-> ($past(sph_q) == 2'd3));
    // R1: no shift clock during the startup hold
    a_r1_hold_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_HOLD) |-> (!sclk && fs_n && !frame_start));

endmodule

// File: rtl/codec_timing_gen.sv
module codec_timing_gen
    import codec_tg_pkg::*;
#(
    parameter int DIV_W       = 8,
    parameter int STARTUP_CYC = 648,
    parameter int FRAME_BITS  = 16
) (
    input  logic             mclk,
    input  logic             rst_n,
    input  logic [DIV_W-1:0] div_a,
    input  logic [DIV_W-1:0] div_b,
    output logic             sclk,
    output logic             fclk,
    output logic             fs_n,
    output logic             frame_start
);
    localparam int FRAME_CYC = FRAME_BITS * SCLK_RATIO;

    logic go, period_end, restart, run;

    tg_startup #(.CYC(STARTUP_CYC)) u_startup (
        .clk   (mclk),
        .rst_n (rst_n),
        .go    (go)
    );

    tg_divchain #(.DIV_W(DIV_W)) u_div (
        .clk        (mclk),
        .rst_n      (rst_n),
        .restart    (restart),
        .run        (run),
        .div_a      (div_a),
        .div_b      (div_b),
        .fclk       (fclk),
        .period_end (period_end)
    );

    tg_frame_fsm #(.FRAME_CYC(FRAME_CYC)) u_fsm (
        .clk         (mclk),
        .rst_n       (rst_n),
        .go          (go),
        .period_end  (period_end),
        .restart     (restart),
        .run         (run),
        .sclk        (sclk),
        .fs_n        (fs_n),
        .frame_start (frame_start)
    );

    // R3: filter clock is silent while the block holds after reset
    a_r3_fclk_hold: assert property (@(posedge mclk) disable iff (!rst_n)
        !run |-> !fclk);

endmodule

// File: tb/codec_timing_gen_tb.sv
module codec_timing_gen_tb;
    localparam int DIV_W   = 8;
    localparam int STARTUP = 648;

    logic             mclk = 1'b0;
    logic             rst_n = 1'b0;
    logic [DIV_W-1:0] div_a = 8'd2;
    logic [DIV_W-1:0] div_b = 8'd20;
    logic             sclk, fclk, fs_n, frame_start;

    int checks = 0;
    int errors = 0;

    always #2.5 mclk = ~mclk;

    codec_timing_gen u_dut (
        .mclk(mclk), .rst_n(rst_n), .div_a(div_a), .div_b(div_b),
        .sclk(sclk), .fclk(fclk), .fs_n(fs_n), .frame_start(frame_start)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic int eff(input int v);
        return (v == 0) ? 1 : v;
    endfunction

    // Entered at the negedge showing k=0 of a period. That period runs with
    // ea/eb; the inputs change to na/nb right now (R7: ignored until next start).
    task automatic measure(input int ea, input int eb, input int na, input int nb);
        int k = 0;
        int bad_s = -1, bad_f = -1, bad_fs = -1, bad_st = -1;
        int plen = 2 * ea * eb;
        div_a = DIV_W'(na);
        div_b = DIV_W'(nb);
        do begin
            if (bad_s  < 0 && sclk != ((k % 4) < 2))              bad_s  = k;
            if (bad_f  < 0 && fclk != (((k / ea) % 2) == 0))      bad_f  = k;
            if (bad_fs < 0 && fs_n != (k >= 64))                  bad_fs = k;
            if (bad_st < 0 && frame_start != (k == 0))            bad_st = k;
            @(negedge mclk);
            k++;
        end while (!frame_start && k <= plen + 8);
        check(bad_s  < 0, "R2", "sclk mismatch at cycle", bad_s, -1);
        check(bad_f  < 0, (ea != eb) ? "R3" : "R3/R8", "fclk mismatch at cycle", bad_f, -1);
        check(bad_fs < 0, "R5", "fs_n mismatch at cycle", bad_fs, -1);
        check(bad_st < 0, "R9", "frame_start mismatch at cycle", bad_st, -1);
        if (na == 0 || nb == 0 || ea == 1 || eb == 1)
            check(k == plen, "R8", "period length (zero clamp)", k, plen);
        else if (eff(na) != ea || eff(nb) != eb)
            check(k == plen, "R7", "period length after divisor change", k, plen);
        else
            check(k == plen, "R4", "period length", k, plen);
    endtask

    initial begin
        #2_000_000;
        errors++;
        $display("FAIL watchdog: actual 1 expected 0");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        int pa, pb, n;
        int hold_bad = -1;
        repeat (3) @(negedge mclk);
        check(fs_n && !sclk && !fclk && !frame_start, "R1", "reset outputs idle",
              {fs_n, sclk, fclk, frame_start}, 4'b1000);
        rst_n = 1'b1;
        // R1: quiet for STARTUP-1 edges, frame on the STARTUP-th edge
        for (int e = 1; e < STARTUP; e++) begin
            @(negedge mclk);
            if (hold_bad < 0 && !(fs_n && !sclk && !fclk && !frame_start)) hold_bad = e;
        end
        check(hold_bad < 0, "R1", "activity during startup hold at edge", hold_bad, -1);
        @(negedge mclk);
        check(!fs_n && frame_start && sclk && fclk, "R1", "first frame on startup edge",
              {fs_n, frame_start, sclk, fclk}, 4'b0111);
        check(sclk, "R6", "sclk high at fs_n fall", sclk, 1);

        pa = 2; pb = 20;
        for (int a = 0; a < 16; a++) begin
            for (int b = 0; b < 16; b++) begin
                measure(pa, pb, a, b);
                pa = eff(a); pb = eff(b);
            end
        end
        measure(pa, pb, pa, pb);

        // R7: a change that lands well inside a long period is ignored by it
        measure(pa, pb, 4, 10);          // period with old values, new latched next
        n = 0;
        div_a = 8'd1; div_b = 8'd1;      // mid-period change inside an A=4,B=10 period
        do begin @(negedge mclk); n++; end while (!frame_start && n < 200);
        check(n == 80, "R7", "period kept old divisors", n, 80);
        measure(1, 1, 1, 1);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule